// File: doc/BRIEF.md
# Big-Endian Byte-Lane Steering Unit

This block sits between a core's 16-bit access request and a 16-bit external data bus made of two byte lanes. It accepts an address, a byte/word size flag, a direction and write data. It decides which lanes carry the transfer under big-endian rules: the even byte address maps to bits 15..8 and the odd byte address maps to bits 7..0. It drives the two active-low lane strobes and a drive enable for each lane. On reads it packs the returned lanes back into the core's view of the data.

A word access to an odd address cannot travel as a single bus transfer, so the block issues it as two ordered byte transfers. The core is held, with no acknowledge, until both transfers are done. A narrow mode is set by `wideBus` low. In that mode every byte travels on the low lane, both strobes stay inactive, and a word becomes two byte transfers. The timing of each bus transfer belongs to an external sequencer. The block hands each transfer over with a one-cycle `seqStart` pulse and treats it as finished when `seqDone` arrives.

The core holds `reqValid` and the request fields stable until it sees `reqAck`. `reqAck` is a one-cycle pulse. For reads, `reqRdata` is valid in that same cycle.

Top module: `byte_lane_steer`

## Requirements
- R1: In wide mode, a byte access to an even address asserts only `extUdsN` (low). The byte travels on bits 15..8 of the bus.
- R2: In wide mode, a byte access to an odd address asserts only `extLdsN` (low). The byte travels on bits 7..0 of the bus.
- R3: In wide mode, a word access to an even address is one transfer with both strobes low. `reqWdata[15:8]` goes on bits 15..8 and `reqWdata[7:0]` goes on bits 7..0. A read returns `extDin` unchanged.
- R4: During a write, only the lanes in use have their drive enable high (`extOeHi`, `extOeLo`). During a read, neither lane is driven.
- R5: In wide mode, a word access to odd address A becomes two transfers. The first is at A with `extLdsN` low and carries `reqWdata[15:8]` on the low lane. The second is at A+1 with `extUdsN` low and carries `reqWdata[7:0]` on the high lane. `extAddr` always shows bits 22..1 of the transfer address.
- R6: A split read returns the byte from the first transfer in `reqRdata[15:8]` and the byte from the second in `reqRdata[7:0]`. A byte read returns its lane in `reqRdata[7:0]`, with zero in `reqRdata[15:8]`.
- R7: Each transfer starts with a one-cycle `seqStart` pulse: one pulse for an unsplit access, two for a split access. `reqAck` is a one-cycle pulse that follows only the `seqDone` of the final transfer. It stays low however long `seqDone` is delayed.
- R8: With `wideBus` low, a byte access at any address uses only bits 7..0. Both strobes stay high and `extOeHi` never rises.
- R9: With `wideBus` low, a word access at address A becomes two low-lane transfers: `reqWdata[15:8]` at A, then `reqWdata[7:0]` at A+1. On a read the word is assembled in that same order.
- R10: Outside a transfer, both strobes are high and both drive enables are low.
- R11: During and straight after reset, `reqAck` and `seqStart` are low, both strobes are high and no lane is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core request pending, held until `reqAck` |
| reqAddr | input | ADDR_W (23) | Byte address of the access |
| reqWord | input | 1 | 1 = word access, 0 = byte access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 16 | Write data; a byte write uses bits 7..0 |
| wideBus | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus on the low lane |
| reqAck | output | 1 | One-cycle completion pulse |
| reqRdata | output | 16 | Assembled read data, valid with `reqAck` |
| seqStart | output | 1 | One-cycle pulse that starts a bus transfer |
| seqDone | input | 1 | Sequencer reports that the transfer has ended |
| extAddr | output | ADDR_W-1 (22) | Transfer address bits 22..1 |
| extUdsN | output | 1 | Active-low strobe for bits 15..8 |
| extLdsN | output | 1 | Active-low strobe for bits 7..0 |
| extOeHi | output | 1 | Drive enable for bits 15..8 |
| extOeLo | output | 1 | Drive enable for bits 7..0 |
| extDout | output | 16 | Data toward the bus |
| extDin | input | 16 | Data from the bus, taken at `seqDone` |
| busWrite | output | 1 | High during a write transfer |

## Verification
The bench builds the block with its default parameters: 8-bit lanes and a 23-bit byte address. With this address width the top of the address space can be reached. A split word at 0x3FFFFF therefore carries a bit-22 change from its first transfer into its second. The vector walk drives all eight combinations of size, alignment and direction in wide mode, plus byte and word accesses in narrow mode. Directed runs hold `seqDone` back for several cycles during split accesses, to show that the acknowledge waits for the final transfer.

// File: rtl/byte_lane_pkg.sv
package byte_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_ACK
  } laneStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch the core request
    logic active;   // a bus transfer is in progress
    logic second;   // second transfer of a split access
    logic capture;  // sequencer finished: sample read lanes
  } laneCtlT;

endpackage

// File: rtl/byte_lane_ctrl.sv
module byte_lane_ctrl
  import byte_lane_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    splitNeeded,
  input  logic    seqDone,
  output logic    seqStart,
  output logic    reqAck,
  output laneCtlT ctl
);

  laneStateT state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_ISSUE1;
      ST_ISSUE1: stateNext = ST_WAIT1;
      ST_WAIT1:  if (seqDone) stateNext = splitNeeded ? ST_ISSUE2 : ST_ACK;
      ST_ISSUE2: stateNext = ST_WAIT2;
      ST_WAIT2:  if (seqDone) stateNext = ST_ACK;
      ST_ACK:    stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.active  = (state == ST_ISSUE1) || (state == ST_WAIT1) ||
                  (state == ST_ISSUE2) || (state == ST_WAIT2);
    ctl.second  = (state == ST_ISSUE2) || (state == ST_WAIT2);
    ctl.capture = ((state == ST_WAIT1) || (state == ST_WAIT2)) && seqDone;
    seqStart    = (state == ST_ISSUE1) || (state == ST_ISSUE2);
    reqAck      = (state == ST_ACK);
  end

  // R7: acknowledge is a single-cycle pulse
  a_r7_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |=> !reqAck);

  // R7: every transfer start is a single-cycle pulse
  a_r7_start_pulse: assert property (@(posedge clk) disable iff (!rstN)
    seqStart |=> !seqStart);

  // R7: acknowledge only follows a sequencer completion
  a_r7_ack_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqAck) |-> $past(seqDone));

  // R7: no transfer start while the acknowledge is out
  a_r7_no_start_at_ack: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> !seqStart);

endmodule

// File: rtl/byte_lane_path.sv
module byte_lane_path
  import byte_lane_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtlT             ctl,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWord,
  input  logic                reqWrite,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic                wideBus,
  input  logic [2*LANE_W-1:0] extDin,
  output logic                splitNeeded,
  output logic [2*LANE_W-1:0] reqRdata,
  output logic [ADDR_W-2:0]   extAddr,
  output logic                extUdsN,
  output logic                extLdsN,
  output logic                extOeHi,
  output logic                extOeLo,
  output logic [2*LANE_W-1:0] extDout,
  output logic                busWrite
);

  localparam int DATA_W = 2 * LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic              wordQ, writeQ, wideQ;
  logic [DATA_W-1:0] wdQ, rdQ;

  logic [ADDR_W-1:0] curAddr;
  logic              fullWord, useHi, useLo;
  logic [LANE_W-1:0] byteOut, laneByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wordQ  <= 1'b0;
      writeQ <= 1'b0;
      wideQ  <= 1'b1;
      wdQ    <= '0;
    end else if (ctl.load) begin
      addrQ  <= reqAddr;
      wordQ  <= reqWord;
      writeQ <= reqWrite;
      wideQ  <= wideBus;
      wdQ    <= reqWdata;
    end
  end

  always_comb begin
    splitNeeded = wordQ && (addrQ[0] || !wideQ);
    fullWord    = wordQ && !splitNeeded;
    curAddr     = ctl.second ? addrQ + ADDR_W'(1) : addrQ;
    useHi       = wideQ && (fullWord || !curAddr[0]);
    useLo       = !wideQ || fullWord || curAddr[0];
    byteOut     = (wordQ && !ctl.second) ? wdQ[DATA_W-1:LANE_W] : wdQ[LANE_W-1:0];
    laneByte    = useHi ? extDin[DATA_W-1:LANE_W] : extDin[LANE_W-1:0];
  end

  assign extAddr  = curAddr[ADDR_W-1:1];
  assign extUdsN  = !(ctl.active && wideQ && useHi);
  assign extLdsN  = !(ctl.active && wideQ && useLo);
  assign extOeHi  = ctl.active && writeQ && useHi;
  assign extOeLo  = ctl.active && writeQ && useLo;
  assign extDout  = fullWord ? wdQ : {byteOut, byteOut};
  assign busWrite = ctl.active && writeQ;
  assign reqRdata = rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ <= '0;
    end else if (ctl.capture) begin
      if (fullWord)         rdQ <= extDin;
      else if (!wordQ)      rdQ <= {{LANE_W{1'b0}}, laneByte};
      else if (!ctl.second) rdQ[DATA_W-1:LANE_W] <= laneByte;
      else                  rdQ[LANE_W-1:0] <= laneByte;
    end
  end

  // R4: a read never drives either lane
  a_r4_read_undriven: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !writeQ) |-> (!extOeHi && !extOeLo));

  // R8: narrow mode keeps both strobes inactive and the high lane off
  a_r8_narrow_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && !wideQ) |-> (extUdsN && extLdsN && !extOeHi));

  // R10: nothing on the bus between transfers
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.active |-> (extUdsN && extLdsN && !extOeHi && !extOeLo));

  // R1 / R2 / R5: a byte transfer in wide mode uses exactly one strobe
  a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.active && wideQ && !fullWord) |-> ($countones({extUdsN, extLdsN}) == 1));

  // R5: the second transfer of a split moves to the next byte address
  a_r5_next_addr: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctl.second) |-> (curAddr == addrQ + ADDR_W'(1)));

endmodule

// File: rtl/byte_lane_steer.sv
module byte_lane_steer
  import byte_lane_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqWord,
  input  logic                reqWrite,
  input  logic [2*LANE_W-1:0] reqWdata,
  input  logic                wideBus,
  output logic                reqAck,
  output logic [2*LANE_W-1:0] reqRdata,
  output logic                seqStart,
  input  logic                seqDone,
  output logic [ADDR_W-2:0]   extAddr,
  output logic                extUdsN,
  output logic                extLdsN,
  output logic                extOeHi,
  output logic                extOeLo,
  output logic [2*LANE_W-1:0] extDout,
  input  logic [2*LANE_W-1:0] extDin,
  output logic                busWrite
);

  laneCtlT ctl;
  logic    splitNeeded;

  byte_lane_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .splitNeeded (splitNeeded),
    .seqDone     (seqDone),
    .seqStart    (seqStart),
    .reqAck      (reqAck),
    .ctl         (ctl)
  );

  byte_lane_path #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqWord     (reqWord),
    .reqWrite    (reqWrite),
    .reqWdata    (reqWdata),
    .wideBus     (wideBus),
    .extDin      (extDin),
    .splitNeeded (splitNeeded),
    .reqRdata    (reqRdata),
    .extAddr     (extAddr),
    .extUdsN     (extUdsN),
    .extLdsN     (extLdsN),
    .extOeHi     (extOeHi),
    .extOeLo     (extOeLo),
    .extDout     (extDout),
    .busWrite    (busWrite)
  );

endmodule

// File: tb/byte_lane_steer_test.sv
module byte_lane_steer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  localparam logic [15:0] DIN0 = 16'h5AC3;
  localparam logic [15:0] DIN1 = 16'h96E1;

  // {wide, word, write, addr[22:0], wdata[15:0]}
  localparam logic [41:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 1'b1, 23'h000100, 16'h00A7},
    {1'b1, 1'b0, 1'b1, 23'h000101, 16'h003C},
    {1'b1, 1'b1, 1'b1, 23'h200010, 16'h1234},
    {1'b1, 1'b1, 1'b1, 23'h3FFFFF, 16'hFF7E},
    {1'b1, 1'b0, 1'b0, 23'h000200, 16'h0000},
    {1'b1, 1'b0, 1'b0, 23'h000203, 16'h0000},
    {1'b1, 1'b1, 1'b0, 23'h123456, 16'h0000},
    {1'b1, 1'b1, 1'b0, 23'h001001, 16'h0000},
    {1'b0, 1'b0, 1'b1, 23'h000050, 16'h00D2},
    {1'b0, 1'b1, 1'b1, 23'h000060, 16'hBE71},
    {1'b0, 1'b1, 1'b0, 23'h000071, 16'h0000},
    {1'b0, 1'b0, 1'b0, 23'h000081, 16'h0000}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [22:0] reqAddr = '0;
  logic        reqWord = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqWdata = '0;
  logic        wideBus = 1'b1;
  logic        reqAck;
  logic [15:0] reqRdata;
  logic        seqStart;
  logic        seqDone = 1'b0;
  logic [21:0] extAddr;
  logic        extUdsN, extLdsN, extOeHi, extOeLo;
  logic [15:0] extDout;
  logic [15:0] extDin = '0;
  logic        busWrite;

  int nChk = 0;
  int nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_lane_steer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqWord(reqWord), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .wideBus(wideBus), .reqAck(reqAck), .reqRdata(reqRdata),
    .seqStart(seqStart), .seqDone(seqDone), .extAddr(extAddr),
    .extUdsN(extUdsN), .extLdsN(extLdsN), .extOeHi(extOeHi),
    .extOeLo(extOeLo), .extDout(extDout), .extDin(extDin),
    .busWrite(busWrite)
  );

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkQuiet(input string req);
    chk(extUdsN == 1'b1 && extLdsN == 1'b1, req, "strobes idle",
        {30'd0, extUdsN, extLdsN}, 32'h3);
    chk(extOeHi == 1'b0 && extOeLo == 1'b0, req, "lanes idle",
        {30'd0, extOeHi, extOeLo}, 32'h0);
  endtask

  // One core access with a sequencer model; doneDelay stretches each transfer
  task automatic runAccess(input logic [41:0] v, input int doneDelay);
    logic        wide, word, wr, split, fullW, hi, lo;
    logic [22:0] addr, opAddr;
    logic [15:0] wd, din, rdExp;
    logic [7:0]  expByte, gotByte;
    string       tag;
    int          nOps, n;
    wide = v[41]; word = v[40]; wr = v[39]; addr = v[38:16]; wd = v[15:0];
    split = word && (addr[0] || !wide);
    fullW = word && !split;
    nOps  = split ? 2 : 1;
    if (!wide)      tag = word ? "R9" : "R8";
    else if (split) tag = "R5";
    else if (word)  tag = "R3";
    else            tag = addr[0] ? "R2" : "R1";
    rdExp = '0;

    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqWord = word; reqWrite = wr;
    reqWdata = wd; wideBus = wide;

    for (int k = 0; k < nOps; k++) begin
      n = 0;
      while (!seqStart && n < 20) begin
        @(negedge clk);
        n++;
      end
      chk(seqStart, "R7", "start pulse seen", {31'd0, seqStart}, 32'h1);
      chk(!reqAck, "R7", "no ack before final done", {31'd0, reqAck}, 32'h0);
      opAddr  = addr + 23'(k);
      hi      = wide && (fullW || !opAddr[0]);
      lo      = !wide || fullW || opAddr[0];
      expByte = (word && k == 0) ? wd[15:8] : wd[7:0];
      chk(extAddr == opAddr[22:1], tag, "address", {10'd0, extAddr}, {10'd0, opAddr[22:1]});
      chk(extUdsN == !(wide && hi), tag, "upper strobe", {31'd0, extUdsN}, {31'd0, !(wide && hi)});
      chk(extLdsN == !(wide && lo), tag, "lower strobe", {31'd0, extLdsN}, {31'd0, !(wide && lo)});
      chk(extOeHi == (wr && hi), "R4", "high lane enable", {31'd0, extOeHi}, {31'd0, wr && hi});
      chk(extOeLo == (wr && lo), "R4", "low lane enable", {31'd0, extOeLo}, {31'd0, wr && lo});
      if (wr && hi)
        chk(extDout[15:8] == (fullW ? wd[15:8] : expByte), tag, "high lane data",
            {24'd0, extDout[15:8]}, {24'd0, fullW ? wd[15:8] : expByte});
      if (wr && lo)
        chk(extDout[7:0] == (fullW ? wd[7:0] : expByte), tag, "low lane data",
            {24'd0, extDout[7:0]}, {24'd0, fullW ? wd[7:0] : expByte});

      din = (k == 0) ? DIN0 : DIN1;
      gotByte = hi ? din[15:8] : din[7:0];
      if (fullW)       rdExp = din;
      else if (!word)  rdExp = {8'h00, gotByte};
      else if (k == 0) rdExp[15:8] = gotByte;
      else             rdExp[7:0] = gotByte;

      @(negedge clk);
      for (int d = 0; d < doneDelay; d++) begin
        chk(!reqAck, "R7", "ack held while done delayed", {31'd0, reqAck}, 32'h0);
        @(negedge clk);
      end
      extDin = din; seqDone = 1'b1;
      @(negedge clk);
      seqDone = 1'b0; extDin = 16'h0000;
    end

    chk(reqAck, "R7", "ack after final done", {31'd0, reqAck}, 32'h1);
    chk(!seqStart, "R7", "no extra start", {31'd0, seqStart}, 32'h0);
    if (!wr)
      chk(reqRdata == rdExp, split ? "R6" : tag, "read data",
          {16'd0, reqRdata}, {16'd0, rdExp});
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqAck, "R7", "ack is one cycle", {31'd0, reqAck}, 32'h0);
    checkQuiet("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 40000);
    nFail++;
    $display("FAIL R7 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    // reset state (R11)
    @(negedge clk);
    chk(!reqAck && !seqStart, "R11", "handshake in reset",
        {30'd0, reqAck, seqStart}, 32'h0);
    checkQuiet("R11");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!reqAck && !seqStart, "R11", "handshake after reset",
        {30'd0, reqAck, seqStart}, 32'h0);
    checkQuiet("R11");

    for (int i = 0; i < NVEC; i++) runAccess(VEC[i], 0);

    // directed: delayed completion on split accesses (R7, R5, R6, R9)
    runAccess({1'b1, 1'b1, 1'b0, 23'h3FFFFF, 16'h0000}, 3);
    runAccess({1'b1, 1'b1, 1'b1, 23'h000011, 16'hA55A}, 2);
    runAccess({1'b0, 1'b1, 1'b0, 23'h000400, 16'h0000}, 4);

    // directed: idle after a narrow write leaves the bus quiet (R8, R10)
    runAccess({1'b0, 1'b0, 1'b1, 23'h000009, 16'h0077}, 1);
    repeat (3) @(negedge clk);
    checkQuiet("R10");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule